// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block sits between a processor and main memory. It holds a 16 KB data cache of 1024 lines, each of four 32-bit words. Each line has a tag, a valid bit and a dirty bit. The processor issues single-word reads and writes. Hits are served from the local arrays. Misses are served by moving whole 128-bit lines to and from memory.

A four-state machine controls the flow: idle, tag compare, write-back and allocate. When a miss lands on a line that holds modified data, that line is first written back to memory. The new line is fetched only after the write-back completes. After the fetch, control returns to the tag compare, which then hits. Memory may take any number of cycles to answer. A memory write counts as finished as soon as memory raises ready.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset, `cpu_ready` and `mem_req` are low and every line is invalid, so the first access to any line misses.
- R2: Address fields: bits [31:14] are the tag, bits [13:4] the line index, bits [3:2] the word within the line, and bits [1:0] are ignored.
- R3: A read hit returns the addressed word with `cpu_ready` high. This happens in the cycle after the request is seen in idle, and no memory request is issued.
- R4: A write hit stores the word into the line and marks the line dirty. Later reads of that word return the new value.
- R5: `cpu_ready` is high for exactly one cycle per access.
- R6: A miss to an invalid or clean line issues exactly one memory read (`mem_we`=0) at address {request tag, index, 4'b0000}.
- R7: A miss to a valid dirty line first issues one memory write (`mem_we`=1) at {stored tag, index, 4'b0000}. The write carries the whole line, with word w in `mem_wdata` bits [32w+31:32w]. The line read is issued only after that write completes.
- R8: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we` and `mem_addr` stay unchanged. Any memory latency, including zero wait cycles, is accepted.
- R9: A line installed by a fetch is clean. Evicting it without an intervening write causes no write-back.
- R10: In the cycle after the fetch completes (`mem_ready` high during a read), `cpu_ready` is high and the access finishes as a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Line being written back |
| mem_rdata | input | 128 | Fetched line, sampled when `mem_ready` is high |
| mem_ready | input | 1 | Memory transfer complete |

## Verification
Two functions can fall in the same cycle:
- the completion of a memory transfer, and
- the controller's move to its next phase, that is, the start of the fetch after a write-back, or the hit that follows the fetch.

The memory model gives random latencies from zero to three wait cycles. A latency of zero makes `mem_ready` rise in the first cycle of a request. Conflicting tags on a few shared indexes force dirty evictions that are directly followed by fetches. The bench judges each access from its own shadow of tags and dirty bits:
- the number and order of memory writes and reads,
- their addresses,
- the written-back line contents, compared with a word-level golden memory,
- that `cpu_ready` arrives exactly one cycle after the fetch completes.

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 4,
  parameter int LINES = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [AW-1:0]       cpu_addr,
  input  logic [DW-1:0]       cpu_wdata,
  output logic [DW-1:0]       cpu_rdata,
  output logic                cpu_ready,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [DW*WORDS-1:0] mem_wdata,
  input  logic [DW*WORDS-1:0] mem_rdata,
  input  logic                mem_ready
);
  localparam int LW   = DW * WORDS;
  localparam int BOFF = $clog2(DW / 8);
  localparam int WOFF = $clog2(WORDS);
  localparam int OFFW = BOFF + WOFF;
  localparam int IW   = $clog2(LINES);
  localparam int TW   = AW - IW - OFFW;

  typedef enum logic [1:0] {S_IDLE, S_CMP, S_WB, S_ALLOC} st_t;

  st_t             st;
  logic [LINES-1:0] vld, drt;
  logic [TW-1:0]   tag_arr [LINES];
  logic [LW-1:0]   dat_arr [LINES];

  logic [TW-1:0]   a_tag;
  logic [IW-1:0]   a_idx;
  logic [WOFF-1:0] a_word;
  logic            unused_bits;
  logic            hit;

  assign a_tag       = cpu_addr[AW-1 -: TW];
  assign a_idx       = cpu_addr[OFFW +: IW];
  assign a_word      = cpu_addr[BOFF +: WOFF];
  assign unused_bits = ^cpu_addr[BOFF-1:0];

  assign hit       = vld[a_idx] && (tag_arr[a_idx] == a_tag);
  assign cpu_ready = (st == S_CMP) && hit;
  assign cpu_rdata = dat_arr[a_idx][DW*a_word +: DW];
  assign mem_req   = (st == S_WB) || (st == S_ALLOC);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = {(st == S_WB) ? tag_arr[a_idx] : a_tag, a_idx, {OFFW{1'b0}}};
  assign mem_wdata = dat_arr[a_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      vld <= '0;
      drt <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (cpu_req) st <= S_CMP;
        S_CMP: begin
          if (hit) begin
            st <= S_IDLE;
            if (cpu_we) drt[a_idx] <= 1'b1;
          end else if (vld[a_idx] && drt[a_idx]) begin
            st <= S_WB;
          end else begin
            st <= S_ALLOC;
          end
        end
        S_WB: if (mem_ready) st <= S_ALLOC;
        S_ALLOC: if (mem_ready) begin
          st         <= S_CMP;
          vld[a_idx] <= 1'b1;
          drt[a_idx] <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_CMP && hit && cpu_we)
      dat_arr[a_idx][DW*a_word +: DW] <= cpu_wdata;
    else if (st == S_ALLOC && mem_ready) begin
      dat_arr[a_idx] <= mem_rdata;
      tag_arr[a_idx] <= a_tag;
    end
  end
endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready
);
  p_ready_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  p_line_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[3:0] == 4'b0000));

  p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  p_wb_then_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ready) |=> (mem_req && !mem_we));

  p_fetch_then_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ready) |=> cpu_ready);

  p_no_mem_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req);
endmodule

bind dm_wb_cache dm_wb_cache_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/dm_wb_cache_tb_top.sv
`timescale 1ns/1ps
module dm_wb_cache_tb_top;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         cpu_req = 0, cpu_we = 0;
  logic [31:0]  cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
  logic         cpu_ready;
  logic         mem_req, mem_we, mem_ready;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata, mem_rdata;

  dm_wb_cache dut_i (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [127:0] mem [int unsigned];
  logic [31:0]  gold [int unsigned];
  logic [17:0]  btag [1024];
  bit           bval [1024];
  bit           bdrt [1024];

  int nw, nr, rd_cyc;
  bit exp_wb;
  logic [31:0] exp_waddr, exp_raddr;

  function automatic logic [31:0] wf(int unsigned wa);
    return (wa * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  function automatic logic [31:0] gword(int unsigned wa);
    return gold.exists(wa) ? gold[wa] : wf(wa);
  endfunction

  function automatic logic [127:0] gline(int unsigned la);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[32*w +: 32] = gword(la*4 + w);
    return l;
  endfunction

  function automatic logic [127:0] mline(int unsigned la);
    logic [127:0] l;
    if (mem.exists(la)) return mem[la];
    for (int w = 0; w < 4; w++) l[32*w +: 32] = wf(la*4 + w);
    return l;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin : memory_model
    int lat;
    int unsigned la;
    mem_ready = 0;
    mem_rdata = '0;
    lat = 0;
    forever begin
      @(negedge clk);
      if (mem_ready) mem_ready = 0;
      else if (mem_req) begin
        if (lat != 0) lat--;
        else begin
          la = mem_addr >> 4;
          if (mem_we) begin
            nw++;
            check(mem_addr == exp_waddr, "R7 write-back address", mem_addr, exp_waddr);
            check(mem_wdata == gline(la), "R7 write-back line", mem_wdata, gline(la));
            mem[la] = mem_wdata;
          end else begin
            nr++;
            check(mem_addr == exp_raddr, "R6 fetch address", mem_addr, exp_raddr);
            if (exp_wb) check(nw == 1, "R7 write-back precedes fetch", nw, 1);
            mem_rdata = mline(la);
            rd_cyc = cyc;
          end
          mem_ready = 1;
          lat = $urandom_range(0, 3);
        end
      end
    end
  end

  task automatic access(bit we, logic [31:0] a, logic [31:0] d);
    logic [9:0]  idx = a[13:4];
    logic [17:0] tg  = a[31:14];
    int unsigned wa  = a >> 2;
    bit hit = bval[idx] && btag[idx] == tg;
    int n = 0;
    logic [31:0] rd;
    exp_wb    = !hit && bval[idx] && bdrt[idx];
    exp_waddr = {btag[idx], idx, 4'b0000};
    exp_raddr = {tg, idx, 4'b0000};
    nw = 0; nr = 0; rd_cyc = -10;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    do begin @(negedge clk); n++; end while (!cpu_ready);
    rd = cpu_rdata;
    cpu_req = 0;
    if (hit) begin
      check(n == 1, "R3 hit latency", n, 1);
      check(nw == 0 && nr == 0, "R3 no memory traffic on hit", {nw, nr}, 0);
    end else begin
      check(nr == 1, "R6 one fetch per miss", nr, 1);
      check(nw == (exp_wb ? 1 : 0), "R7/R9 write-back count", nw, exp_wb);
      check(cyc == rd_cyc + 1, "R10 ready right after fetch", cyc, rd_cyc + 1);
    end
    if (we) gold[wa] = d;
    else check(rd == gword(wa), "R3/R4 read data", rd, gword(wa));
    bdrt[idx] = hit ? (bdrt[idx] | we) : we;
    bval[idx] = 1;
    btag[idx] = tg;
    @(negedge clk);
    check(!cpu_ready, "R5 ready single pulse", cpu_ready, 0);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    bad++; total++;
    $display("FAIL R8 watchdog expired act=%0d exp=<150000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!cpu_ready && !mem_req, "R1 reset outputs", {cpu_ready, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!cpu_ready && !mem_req, "R1 idle after reset", {cpu_ready, mem_req}, 0);
    access(0, 32'h0000_0040, 0);          // R1 cold miss, R6 clean fetch
    access(0, 32'h0000_0048, 0);          // R3 read hit
    access(1, 32'h0000_0044, 32'hCAFE_0001); // R4 write hit
    access(0, 32'h0000_0047, 0);          // R2 byte offset ignored
    access(0, 32'h0001_0044, 0);          // R7 dirty eviction, same index
    access(0, 32'h0000_0044, 0);          // R9 clean eviction, old data back from memory
    access(1, 32'h0004_0000, 32'h1234_5678); // write miss allocates then writes
    access(0, 32'h0008_0000, 0);          // R7 dirty eviction of written-miss line
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      a = {$urandom_range(0, 3) == 0 ? 14'h3 : 14'($urandom_range(0, 3)), 4'b0, 6'($urandom_range(0, 7)), 4'($urandom)};
      a[31:14] = 18'($urandom_range(0, 3));
      access(1'($urandom), a, $urandom);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule